// File: doc/BRIEF.md
# Iterative 256-bit Sponge Permutation Core

This core applies one fixed 256-bit permutation to a state presented as eight 32-bit words. Word k occupies bits `32k+31 : 32k` of the state bus. A start pulse loads the state. On that load, a one-time tweak rotates the upper four words. The core then runs eight rounds, one per clock. Each round has three steps in this order:

1. A bit-sliced 4-bit substitution.
2. A mixing of word pairs.
3. The addition of a round constant that the environment supplies.

A wrapper drives the per-round constant on `rconst_i` while the core is busy, and takes the result when `done_o` pulses. The wrapper is responsible for constant generation, message injection and the surrounding hash mode. The 2-bit permutation index selects the tweak amount, so one core can serve every lane of a multi-lane construction.

Top module: `perm256_core`

## Requirements
- R1: While reset is asserted and after its release, `busy_o` is 0, `done_o` is 0 and `state_o` is all zeros until the first accepted start.
- R2: A start seen while `busy_o` is 0 is accepted. `busy_o` is then high for exactly 8 cycles starting in the next cycle. In the cycle after the last busy cycle, `done_o` is high for one cycle and `busy_o` is 0.
- R3: A start seen while `busy_o` is 1 is ignored. The busy length, the `done_o` timing and the result are the same as with no such pulse.
- R4: On an accepted start, words 4..7 of `state_i` are each rotated left by `perm_idx_i` bits (0, 1, 2 or 3). Index 0 gives no rotation. Words 0..3 are loaded unchanged.
- R5: The substitution maps a nibble v to entry v of the table 13,14,0,1,5,10,7,6,11,3,9,12,15,8,2,4. It is applied at every bit position b.
  - In the first group, nibble bit j is bit b of word j, for j = 0..3.
  - In the second group, nibble bits 0,1,2,3 are bit b of words 5,6,7,4 in that order.
  - Each result bit is written back to the word it was taken from.
- R6: After substitution, each pair (k, k+4) for k = 0..3 is mixed with 32-bit left rotations. With b = word k+4 and a = word k, the steps are applied in sequence:
  1. b ^= a
  2. a = rotl(a,2) ^ b
  3. b = rotl(b,14) ^ a
  4. a = rotl(a,10) ^ b
  5. b = rotl(b,1)
- R7: After mixing, bits 31:0 of `rconst_i` are XORed into word 0 and bits 63:32 into word 4.
- R8: Round r (r = 0..7) uses the value of `rconst_i` present during the r-th busy cycle. The value of `state_o` while `done_o` is high is the result of the tweak followed by eight rounds.
- R9: While `busy_o` is 0 and no start arrives, `state_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted when idle |
| perm_idx_i | input | 2 | Permutation index; tweak rotation amount |
| state_i | input | 256 | Input state, word k at bits 32k+31:32k |
| rconst_i | input | 64 | Round constant for the current busy cycle |
| busy_o | output | 1 | High while rounds are running |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| state_o | output | 256 | Current state; final result from done on |

## Verification
The bench starts permutations with every permutation index, with an all-zero state and zero constants, and with random states and constants.

- A wrong tweak amount, or a tweak applied to the lower words, gives a wrong result only for the nonzero indices.
- A swapped word order in the second substitution group is visible in a result that changes from the very first round.
- A constant taken one cycle late, or XORed into the wrong word, corrupts the constant-only runs.

Start pulses arrive in the middle of a busy run and in the same cycle as the done pulse. A design that restarts on a busy start would stretch `busy_o` and change the result. A design that refuses the start in the done cycle would miss a back-to-back run.

// File: rtl/perm256_pkg.sv
package perm256_pkg;
  localparam int WORD_W  = 32;
  localparam int NWORDS  = 8;
  localparam int HALF    = NWORDS / 2;
  localparam int STATE_W = WORD_W * NWORDS;
  localparam int RC_W    = 2 * WORD_W;
  localparam int IDX_W   = 2;
  localparam int ROUNDS  = 8;

  localparam int MIX_ROT_A0 = 2;
  localparam int MIX_ROT_B0 = 14;
  localparam int MIX_ROT_A1 = 10;
  localparam int MIX_ROT_B1 = 1;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t rotl(input word_t x, input int n);
    rotl = (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [3:0] sbox4(input logic [3:0] v);
    case (v)
      4'd0:    sbox4 = 4'd13;
      4'd1:    sbox4 = 4'd14;
      4'd2:    sbox4 = 4'd0;
      4'd3:    sbox4 = 4'd1;
      4'd4:    sbox4 = 4'd5;
      4'd5:    sbox4 = 4'd10;
      4'd6:    sbox4 = 4'd7;
      4'd7:    sbox4 = 4'd6;
      4'd8:    sbox4 = 4'd11;
      4'd9:    sbox4 = 4'd3;
      4'd10:   sbox4 = 4'd9;
      4'd11:   sbox4 = 4'd12;
      4'd12:   sbox4 = 4'd15;
      4'd13:   sbox4 = 4'd8;
      4'd14:   sbox4 = 4'd2;
      default: sbox4 = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/perm256_subcol.sv
module perm256_subcol
  import perm256_pkg::*;
#(
  parameter int COL_W = WORD_W
) (
  input  logic [COL_W-1:0] a0_i,
  input  logic [COL_W-1:0] a1_i,
  input  logic [COL_W-1:0] a2_i,
  input  logic [COL_W-1:0] a3_i,
  output logic [COL_W-1:0] y0_o,
  output logic [COL_W-1:0] y1_o,
  output logic [COL_W-1:0] y2_o,
  output logic [COL_W-1:0] y3_o
);
  for (genvar b = 0; b < COL_W; b++) begin : g_col
    logic [3:0] nib_in;
    logic [3:0] nib_out;
    assign nib_in  = {a3_i[b], a2_i[b], a1_i[b], a0_i[b]};
    assign nib_out = sbox4(nib_in);
    assign y0_o[b] = nib_out[0];
    assign y1_o[b] = nib_out[1];
    assign y2_o[b] = nib_out[2];
    assign y3_o[b] = nib_out[3];
  end
endmodule

// File: rtl/perm256_mixpair.sv
module perm256_mixpair
  import perm256_pkg::*;
(
  input  word_t lo_i,
  input  word_t hi_i,
  output word_t lo_o,
  output word_t hi_o
);
  word_t h1, l1, h2, l2;

  always_comb begin
    h1   = hi_i ^ lo_i;
    l1   = rotl(lo_i, MIX_ROT_A0) ^ h1;
    h2   = rotl(h1, MIX_ROT_B0) ^ l1;
    l2   = rotl(l1, MIX_ROT_A1) ^ h2;
    lo_o = l2;
    hi_o = rotl(h2, MIX_ROT_B1);
  end
endmodule

// File: rtl/perm256_round.sv
module perm256_round
  import perm256_pkg::*;
(
  input  logic [STATE_W-1:0] st_i,
  input  logic [RC_W-1:0]    rc_i,
  output logic [STATE_W-1:0] st_o
);
  word_t w_in  [NWORDS];
  word_t w_sub [NWORDS];
  word_t w_mix [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_unpack
    assign w_in[k] = st_i[k*WORD_W +: WORD_W];
  end

  // first group: words 0,1,2,3 as nibble bits 0..3
  perm256_subcol #(.COL_W(WORD_W)) u_sub_lo (
    .a0_i(w_in[0]), .a1_i(w_in[1]), .a2_i(w_in[2]), .a3_i(w_in[3]),
    .y0_o(w_sub[0]), .y1_o(w_sub[1]), .y2_o(w_sub[2]), .y3_o(w_sub[3])
  );

  // second group: words 5,6,7,4 as nibble bits 0..3
  perm256_subcol #(.COL_W(WORD_W)) u_sub_hi (
    .a0_i(w_in[5]), .a1_i(w_in[6]), .a2_i(w_in[7]), .a3_i(w_in[4]),
    .y0_o(w_sub[5]), .y1_o(w_sub[6]), .y2_o(w_sub[7]), .y3_o(w_sub[4])
  );

  for (genvar k = 0; k < HALF; k++) begin : g_mix
    perm256_mixpair u_mix (
      .lo_i(w_sub[k]), .hi_i(w_sub[k+HALF]),
      .lo_o(w_mix[k]), .hi_o(w_mix[k+HALF])
    );
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_pack
    if (k == 0) begin : g_rc_lo
      assign st_o[k*WORD_W +: WORD_W] = w_mix[k] ^ rc_i[WORD_W-1:0];
    end else if (k == HALF) begin : g_rc_hi
      assign st_o[k*WORD_W +: WORD_W] = w_mix[k] ^ rc_i[RC_W-1:WORD_W];
    end else begin : g_pass
      assign st_o[k*WORD_W +: WORD_W] = w_mix[k];
    end
  end
endmodule

// File: rtl/perm256_ctrl.sv
module perm256_ctrl
  import perm256_pkg::*;
#(
  parameter int NROUNDS = ROUNDS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = (NROUNDS > 1) ? $clog2(NROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NROUNDS - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] rnd_q, rnd_d;
  logic             last_rnd;

  assign last_rnd = (rnd_q == LAST);
  assign load_o   = start_i && !busy_q;
  assign step_o   = busy_q;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    done_d = 1'b0;
    if (busy_q) begin
      rnd_d = rnd_q + CNT_W'(1);
      if (last_rnd) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      rnd_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rnd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rnd_q  <= rnd_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/perm256_core.sv
module perm256_core
  import perm256_pkg::*;
#(
  parameter int NROUNDS = ROUNDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [IDX_W-1:0]   perm_idx_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [RC_W-1:0]    rconst_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [STATE_W-1:0] state_o
);
  logic               load, step, st_en;
  logic [STATE_W-1:0] state_q, state_d, tweaked, rnd_out;

  perm256_ctrl #(.NROUNDS(NROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load), .step_o(step), .busy_o(busy_o), .done_o(done_o)
  );

  perm256_round u_round (
    .st_i(state_q), .rc_i(rconst_i), .st_o(rnd_out)
  );

  for (genvar k = 0; k < NWORDS; k++) begin : g_tweak
    if (k < HALF) begin : g_keep
      assign tweaked[k*WORD_W +: WORD_W] = state_i[k*WORD_W +: WORD_W];
    end else begin : g_rot
      assign tweaked[k*WORD_W +: WORD_W] =
        rotl(state_i[k*WORD_W +: WORD_W], int'(perm_idx_i));
    end
  end

  assign st_en = load || step;

  always_comb begin
    state_d = state_q;
    if (load)      state_d = tweaked;
    else if (step) state_d = rnd_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= '0;
    else if (st_en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/perm256_core_chk.sv
module perm256_core_chk
  import perm256_pkg::*;
#(
  parameter int NROUNDS = ROUNDS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [STATE_W-1:0] state_o
);
  localparam int BC_W = $clog2(NROUNDS + 2);
  logic [BC_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + BC_W'(1);
    else             busy_cnt <= '0;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_cnt == BC_W'(NROUNDS)));
  p_busy_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && busy_cnt < BC_W'(NROUNDS - 1)) |=> busy_o);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(state_o));
endmodule

bind perm256_core perm256_core_chk #(.NROUNDS(NROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i),
  .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
);

// File: tb/perm256_core_tb.sv
module perm256_core_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   perm_idx_i;
  logic [255:0] state_i;
  logic [63:0]  rconst_i;
  logic         busy_o, done_o;
  logic [255:0] state_o;

  int tests = 0;
  int fails = 0;
  string cur_req = "R1";
  bit rc_zero = 1'b0;

  always #2 clk = ~clk;

  perm256_core u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .perm_idx_i(perm_idx_i),
    .state_i(state_i), .rconst_i(rconst_i),
    .busy_o(busy_o), .done_o(done_o), .state_o(state_o)
  );

  // ---------------- behavioural reference ----------------
  int sb[16] = '{13,14,0,1,5,10,7,6,11,3,9,12,15,8,2,4};
  logic [31:0] m_w[8];
  bit m_busy, m_done;
  int m_rnd;

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [31:0] r = x;
    for (int i = 0; i < n; i++) r = {r[30:0], r[31]};
    return r;
  endfunction

  task automatic ref_round(input logic [63:0] rc);
    logic [31:0] t[8];
    int grp[2][4] = '{'{0,1,2,3}, '{5,6,7,4}};
    for (int i = 0; i < 8; i++) t[i] = m_w[i];
    for (int g = 0; g < 2; g++)
      for (int b = 0; b < 32; b++) begin
        int v = 0;
        for (int j = 0; j < 4; j++) v += int'(m_w[grp[g][j]][b]) << j;
        v = sb[v];
        for (int j = 0; j < 4; j++) t[grp[g][j]][b] = v[j];
      end
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a = t[k], b = t[k+4];
      b = b ^ a;
      a = rl(a, 2) ^ b;
      b = rl(b, 14) ^ a;
      a = rl(a, 10) ^ b;
      b = rl(b, 1);
      t[k] = a; t[k+4] = b;
    end
    t[0] ^= rc[31:0];
    t[4] ^= rc[63:32];
    for (int i = 0; i < 8; i++) m_w[i] = t[i];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_rnd = 0;
      for (int i = 0; i < 8; i++) m_w[i] = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        ref_round(rconst_i);
        m_rnd++;
        if (m_rnd == 8) begin m_busy = 0; m_done = 1; end
      end else if (start_i) begin
        for (int i = 0; i < 8; i++)
          m_w[i] = (i < 4) ? state_i[32*i +: 32] : rl(state_i[32*i +: 32], int'(perm_idx_i));
        m_busy = 1; m_rnd = 0;
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  task automatic check(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [255:0] ex;
      for (int i = 0; i < 8; i++) ex[32*i +: 32] = m_w[i];
      check("R2", "busy_o", 256'(busy_o), 256'(m_busy));
      check("R2", "done_o", 256'(done_o), 256'(m_done));
      if (m_done)       check(cur_req, "result", state_o, ex);
      else if (!m_busy) check("R9", "idle state_o", state_o, ex);
      rconst_i = rc_zero ? 64'd0 : {$urandom, $urandom};
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  task automatic kick(input logic [1:0] idx, input logic [255:0] d);
    @(negedge clk);
    start_i = 1'b1; perm_idx_i = idx; state_i = d;
    @(negedge clk);
    start_i = 1'b0; state_i = rnd256(); perm_idx_i = 2'(~idx);
  endtask

  task automatic run(input logic [1:0] idx, input logic [255:0] d);
    kick(idx, d);
    repeat (10) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    start_i = 0; perm_idx_i = 0; state_i = '0; rconst_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "busy in reset", 256'(busy_o), 256'd0);
    check("R1", "done in reset", 256'(done_o), 256'd0);
    check("R1", "state in reset", state_o, 256'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5: all-zero state, zero constants (every column sees S-box input 0)
    cur_req = "R5"; rc_zero = 1;
    run(2'd0, '0);
    // R7: zero state, only constants act
    cur_req = "R7"; rc_zero = 0;
    run(2'd0, '0);
    // R4: each tweak index on the same state
    cur_req = "R4"; rc_zero = 1;
    for (int i = 0; i < 4; i++) run(2'(i), 256'h0123456789abcdef_fedcba9876543210_00000001_80000000_0f0f0f0f_f0f0f0f0);
    // R6: single-bit states expose mixing rotations
    cur_req = "R6";
    run(2'd0, 256'd1);
    run(2'd0, 256'd1 << 128);
    // R8: random states and constants
    cur_req = "R8"; rc_zero = 0;
    for (int i = 0; i < 6; i++) run(2'($urandom), rnd256());

    // R3: start pulses while busy are ignored
    cur_req = "R3";
    kick(2'd1, rnd256());
    repeat (2) @(negedge clk);
    start_i = 1; state_i = rnd256(); perm_idx_i = 2'd3;
    @(negedge clk); start_i = 0;
    repeat (3) @(negedge clk);
    start_i = 1; state_i = rnd256();
    @(negedge clk); start_i = 0;
    repeat (6) @(negedge clk);

    // R2: start held high, accepted again in the done cycle
    cur_req = "R2";
    @(negedge clk);
    start_i = 1; state_i = rnd256(); perm_idx_i = 2'd2;
    repeat (30) @(negedge clk);
    start_i = 0;
    repeat (12) @(negedge clk);

    // R9: idle hold with changing inputs
    for (int i = 0; i < 4; i++) begin
      state_i = rnd256(); perm_idx_i = 2'($urandom);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule